// File: doc/BRIEF.md
# Integer Load Address and Extension Unit

This unit carries out integer loads for one stage of a 32-bit processor pipeline. The register-read stage hands it an operation: access size, extension kind, whether the operation is an update form, and whether the address uses an index register or a displacement. It also receives the two register numbers and the operand values. The unit forms the effective address and issues a single read on an in-order data memory port with a one-cycle response latency. It then picks the addressed byte or half-word out of the returned big-endian word. It widens the result by zero or sign extension and presents it as a destination register write. Update forms also return the effective address as a write to the base register in the same cycle.

Accesses that are not naturally aligned, and operation encodings that cannot be executed, are rejected before any memory traffic happens. Each raises a one-cycle flag and writes no register. The unit holds one operation at a time and lowers its ready output while that operation is in flight. This keeps loads in program order.

Top module: `int_load_unit`

## Requirements
- R1: The effective address is the base value plus the displacement sign-extended from 16 to 32 bits (displacement form), or the base value plus the index value (indexed form), wrapping modulo 2^32; it appears on `mem_addr_o` during the request cycle.
- R2: In a non-update form whose base register number is 0, the base value is taken as zero and `ra_val_i` is ignored.
- R3: Size code 2'b00 loads a byte, zero-extended; memory is big-endian, so address offset k (the two low address bits) selects returned bits [31-8k:24-8k].
- R4: Size code 2'b01 with `op_signed_i`=0 loads a half-word, zero-extended; offset 0 selects bits [31:16] and offset 2 selects bits [15:0].
- R5: Size code 2'b01 with `op_signed_i`=1 copies bit 15 of the selected half-word into bits [31:16] of the result.
- R6: Size code 2'b10 loads the whole returned word unchanged; `op_signed_i` has no effect on byte or word results.
- R7: An update form writes the effective address to base register `op_ra_i` with `ra_we_o`, in the same cycle as the destination write; a non-update form never raises `ra_we_o`.
- R8: A half-word at an odd address, or a word at an address not a multiple of 4, raises `misalign_o` for one cycle, issues no memory request and writes no register.
- R9: An update form with base register 0 or with base equal to destination, or size code 2'b11, raises `badform_o` for one cycle, issues no request and writes no register; it takes precedence over misalignment, which is then not flagged.
- R10: Out of reset `op_ready_o` is 1 and all strobes are 0; an accepted operation lowers `op_ready_o`, raises `mem_req_o` for exactly one cycle, waits for `mem_rvalid_i`, then raises `rd_we_o` for exactly one cycle, after which `op_ready_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Unit idle and able to accept |
| op_size_i | input | 2 | 00 byte, 01 half-word, 10 word, 11 invalid |
| op_signed_i | input | 1 | Sign-extend half-word loads |
| op_update_i | input | 1 | Update form: write address to base register |
| op_indexed_i | input | 1 | Use index register instead of displacement |
| op_rd_i | input | 5 | Destination register number |
| op_ra_i | input | 5 | Base register number |
| ra_val_i | input | 32 | Base register value |
| rb_val_i | input | 32 | Index register value |
| disp_i | input | 16 | Signed displacement |
| mem_req_o | output | 1 | Read request strobe |
| mem_addr_o | output | 32 | Effective byte address |
| mem_size_o | output | 2 | Access size code |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Returned aligned word, big-endian |
| rd_we_o | output | 1 | Destination write strobe |
| rd_idx_o | output | 5 | Destination register number |
| rd_data_o | output | 32 | Extended load result |
| ra_we_o | output | 1 | Base register write strobe |
| ra_idx_o | output | 5 | Base register number |
| ra_data_o | output | 32 | Effective address for base write-back |
| misalign_o | output | 1 | Misaligned access pulse |
| badform_o | output | 1 | Invalid operation form pulse |

## Verification
Wrong captured operation fields show up at the ports within three cycles of acceptance. A stale size or offset gives a wrong lane or extension in the single write cycle. A lost update bit drops or adds the base write in that same cycle. A wrong address is already visible on the request one cycle after acceptance. A wrong state sequence shows as a request or write strobe lasting more or less than one cycle, or as the ready output failing to return right after the write or error pulse. These are checked for every size, offset, extension and form combination.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } ld_size_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_WB   = 3'd3,
    ST_ERR  = 3'd4
  } ld_state_e;

endpackage

// File: rtl/ldu_agen.sv
module ldu_agen
  import ldu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int RAW    = 5
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   index_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              indexed_i,
  input  logic              update_i,
  input  logic [RAW-1:0]    ra_i,
  input  logic [RAW-1:0]    rd_i,
  input  ld_size_e          size_i,
  output logic [XLEN-1:0]   ea_o,
  output logic              misalign_o,
  output logic              badform_o
);
  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);

  function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [XLEN-1:0] form_ea(
    input logic [XLEN-1:0]   base,
    input logic [XLEN-1:0]   idx,
    input logic [DISP_W-1:0] d,
    input logic              use_idx,
    input logic              zero_base
  );
    logic [XLEN-1:0] b;
    b = zero_base ? '0 : base;
    return b + (use_idx ? idx : sext_disp(d));
  endfunction

  function automatic logic off_bad(input ld_size_e sz, input logic [OW-1:0] off);
    case (sz)
      SZ_HALF: return off[0];
      SZ_WORD: return off != '0;
      default: return 1'b0;
    endcase
  endfunction

  logic ra_zero;
  logic form_bad;

  assign ra_zero   = (ra_i == '0);
  assign ea_o      = form_ea(base_i, index_i, disp_i, indexed_i, ra_zero && !update_i);
  assign form_bad  = (size_i == SZ_BAD) || (update_i && (ra_zero || ra_i == rd_i));
  assign badform_o = form_bad;
  assign misalign_o = !form_bad && off_bad(size_i, ea_o[OW-1:0]);

endmodule

// File: rtl/ldu_extend.sv
module ldu_extend
  import ldu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] word_i,
  input  logic [$clog2(XLEN/8)-1:0] off_i,
  input  ld_size_e        size_i,
  input  logic            signed_i,
  output logic [XLEN-1:0] data_o
);
  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);

  function automatic logic [XLEN-1:0] pick_lane(
    input logic [XLEN-1:0] w,
    input logic [OW-1:0]   off,
    input ld_size_e        sz,
    input logic            sgn
  );
    logic [XLEN-1:0] sh;
    int              amt;
    case (sz)
      SZ_BYTE: begin
        amt = 8 * (NB - 1 - int'(off));
        sh  = w >> amt;
        return {{(XLEN-8){1'b0}}, sh[7:0]};
      end
      SZ_HALF: begin
        amt = 8 * (NB - 2 - int'(off));
        if (amt < 0) amt = 0;
        sh  = w >> amt;
        return {{(XLEN-16){sgn & sh[15]}}, sh[15:0]};
      end
      default: return w;
    endcase
  endfunction

  assign data_o = pick_lane(word_i, off_i, size_i, signed_i);

endmodule

// File: rtl/ldu_ctrl.sv
module ldu_ctrl
  import ldu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  output logic            op_ready_o,
  input  ld_size_e        size_i,
  input  logic            signed_i,
  input  logic            update_i,
  input  logic [RAW-1:0]  rd_i,
  input  logic [RAW-1:0]  ra_i,
  input  logic [XLEN-1:0] ea_i,
  input  logic            mis_i,
  input  logic            bad_i,
  output ld_size_e        size_q_o,
  output logic            signed_q_o,
  output logic [XLEN-1:0] ea_q_o,
  input  logic [XLEN-1:0] ext_data_i,
  output logic            mem_req_o,
  input  logic            mem_rvalid_i,
  output logic            rd_we_o,
  output logic [RAW-1:0]  rd_idx_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            ra_we_o,
  output logic [RAW-1:0]  ra_idx_o,
  output logic            misalign_o,
  output logic            badform_o
);
  ld_state_e       state_q, state_d;
  ld_size_e        size_q;
  logic            sgn_q, upd_q, mis_q, bad_q;
  logic [RAW-1:0]  rd_q, ra_q;
  logic [XLEN-1:0] ea_q, data_q;
  logic            accept_w, resp_w;

  assign accept_w = op_valid_i && (state_q == ST_IDLE);
  assign resp_w   = (state_q == ST_WAIT) && mem_rvalid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (op_valid_i) state_d = (mis_i || bad_i) ? ST_ERR : ST_REQ;
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      sgn_q   <= 1'b0;
      upd_q   <= 1'b0;
      mis_q   <= 1'b0;
      bad_q   <= 1'b0;
      rd_q    <= '0;
      ra_q    <= '0;
      ea_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        size_q <= size_i;
        sgn_q  <= signed_i;
        upd_q  <= update_i;
        mis_q  <= mis_i && !bad_i;
        bad_q  <= bad_i;
        rd_q   <= rd_i;
        ra_q   <= ra_i;
        ea_q   <= ea_i;
      end
      if (resp_w) data_q <= ext_data_i;
    end
  end

  assign op_ready_o = (state_q == ST_IDLE);
  assign mem_req_o  = (state_q == ST_REQ);
  assign size_q_o   = size_q;
  assign signed_q_o = sgn_q;
  assign ea_q_o     = ea_q;
  assign rd_we_o    = (state_q == ST_WB);
  assign ra_we_o    = (state_q == ST_WB) && upd_q;
  assign rd_idx_o   = rd_q;
  assign ra_idx_o   = ra_q;
  assign rd_data_o  = data_q;
  assign misalign_o = (state_q == ST_ERR) && mis_q;
  assign badform_o  = (state_q == ST_ERR) && bad_q;

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  // R10
  wb_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> $past(mem_rvalid_i));

  // R9
  base_wb_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we_o |-> (rd_we_o && ra_idx_o != '0 && ra_idx_o != rd_idx_o));

  // R8
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !((size_q == SZ_HALF && ea_q[0]) || (size_q == SZ_WORD && ea_q[1:0] != 2'b00)));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_o || badform_o) |=> (op_ready_o && !misalign_o && !badform_o));

  // R9
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(misalign_o && badform_o));

endmodule

// File: rtl/int_load_unit.sv
module int_load_unit
  import ldu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int RAW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [1:0]        op_size_i,
  input  logic              op_signed_i,
  input  logic              op_update_i,
  input  logic              op_indexed_i,
  input  logic [RAW-1:0]    op_rd_i,
  input  logic [RAW-1:0]    op_ra_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              mem_req_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [1:0]        mem_size_o,
  input  logic              mem_rvalid_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              rd_we_o,
  output logic [RAW-1:0]    rd_idx_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              ra_we_o,
  output logic [RAW-1:0]    ra_idx_o,
  output logic [XLEN-1:0]   ra_data_o,
  output logic              misalign_o,
  output logic              badform_o
);
  localparam int OW = $clog2(XLEN / 8);

  ld_size_e        size_in_w, size_q_w;
  logic            sgn_q_w;
  logic [XLEN-1:0] ea_w, ea_q_w, ext_w;
  logic            mis_w, bad_w;

  assign size_in_w = ld_size_e'(op_size_i);

  ldu_agen #(.XLEN(XLEN), .DISP_W(DISP_W), .RAW(RAW)) u_agen (
    .base_i     (ra_val_i),
    .index_i    (rb_val_i),
    .disp_i     (disp_i),
    .indexed_i  (op_indexed_i),
    .update_i   (op_update_i),
    .ra_i       (op_ra_i),
    .rd_i       (op_rd_i),
    .size_i     (size_in_w),
    .ea_o       (ea_w),
    .misalign_o (mis_w),
    .badform_o  (bad_w)
  );

  ldu_extend #(.XLEN(XLEN)) u_ext (
    .word_i   (mem_rdata_i),
    .off_i    (ea_q_w[OW-1:0]),
    .size_i   (size_q_w),
    .signed_i (sgn_q_w),
    .data_o   (ext_w)
  );

  ldu_ctrl #(.XLEN(XLEN), .RAW(RAW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid_i),
    .op_ready_o   (op_ready_o),
    .size_i       (size_in_w),
    .signed_i     (op_signed_i),
    .update_i     (op_update_i),
    .rd_i         (op_rd_i),
    .ra_i         (op_ra_i),
    .ea_i         (ea_w),
    .mis_i        (mis_w),
    .bad_i        (bad_w),
    .size_q_o     (size_q_w),
    .signed_q_o   (sgn_q_w),
    .ea_q_o       (ea_q_w),
    .ext_data_i   (ext_w),
    .mem_req_o    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .rd_we_o      (rd_we_o),
    .rd_idx_o     (rd_idx_o),
    .rd_data_o    (rd_data_o),
    .ra_we_o      (ra_we_o),
    .ra_idx_o     (ra_idx_o),
    .misalign_o   (misalign_o),
    .badform_o    (badform_o)
  );

  assign mem_addr_o = ea_q_w;
  assign mem_size_o = size_q_w;
  assign ra_data_o  = ea_q_w;

endmodule

// File: tb/int_load_unit_tb.sv
module int_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = 2'b00;
  logic        op_signed = 1'b0, op_update = 1'b0, op_indexed = 1'b0;
  logic [4:0]  op_rd = '0, op_ra = '0;
  logic [31:0] ra_val = '0, rb_val = '0;
  logic [15:0] disp = '0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [1:0]  mem_size;
  logic        rd_we, ra_we, misalign, badform;
  logic [4:0]  rd_idx, ra_idx;
  logic [31:0] rd_data, ra_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  int_load_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .op_size_i(op_size), .op_signed_i(op_signed), .op_update_i(op_update),
    .op_indexed_i(op_indexed), .op_rd_i(op_rd), .op_ra_i(op_ra),
    .ra_val_i(ra_val), .rb_val_i(rb_val), .disp_i(disp),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rd_we_o(rd_we), .rd_idx_o(rd_idx), .rd_data_o(rd_data),
    .ra_we_o(ra_we), .ra_idx_o(ra_idx), .ra_data_o(ra_data),
    .misalign_o(misalign), .badform_o(badform)
  );

  function automatic logic [31:0] pat(input logic [29:0] widx);
    return 32'h9A3C_57E1 + {2'b00, widx} * 32'h1357_9BDF;
  endfunction

  // memory: one-cycle read latency, word returned for the address's word index
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= pat(mem_addr[31:2]);
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=%h expected=%h", cycles, 0);
      summary();
    end
  end

  function automatic logic [31:0] model_data(input logic [1:0] sz, input logic sg,
                                             input logic [31:0] ea);
    logic [31:0] w, v;
    int k;
    w = pat(ea[31:2]);
    k = int'(ea[1:0]);
    if (sz == 2'b00) v = (w >> (24 - 8 * k)) & 32'hFF;
    else if (sz == 2'b01) begin
      v = (w >> (16 - 8 * k)) & 32'hFFFF;
      if (sg && v[15]) v = v | 32'hFFFF_0000;
    end else v = w;
    return v;
  endfunction

  task automatic run(input logic [1:0] sz, input logic sg, input logic up, input logic ix,
                     input logic [4:0] rd, input logic [4:0] ra, input logic [31:0] base,
                     input logic [31:0] rb, input logic [15:0] d, input string areq);
    logic [31:0] b, ea, exp_data;
    logic        exp_bad, exp_mis, seen_req, done;
    logic [31:0] seen_addr;
    logic [1:0]  seen_size;
    string       dreq;
    b  = (ra == 5'd0 && !up) ? 32'h0 : base;
    ea = b + (ix ? rb : {{16{d[15]}}, d});
    exp_bad = (sz == 2'b11) || (up && (ra == 5'd0 || ra == rd));
    exp_mis = !exp_bad && ((sz == 2'b01 && ea[0]) || (sz == 2'b10 && ea[1:0] != 2'b00));
    exp_data = model_data(sz, sg, ea);
    dreq = (sz == 2'b00) ? "R3" : (sz == 2'b01) ? (sg ? "R5" : "R4") : "R6";

    @(negedge clk);
    op_size = sz; op_signed = sg; op_update = up; op_indexed = ix;
    op_rd = rd; op_ra = ra; ra_val = base; rb_val = rb; disp = d; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    seen_req = 1'b0; seen_addr = '0; seen_size = '0; done = 1'b0;
    for (int i = 0; i < 8 && !done; i++) begin
      if (i > 0) @(negedge clk);
      if (mem_req) begin seen_req = 1'b1; seen_addr = mem_addr; seen_size = mem_size; end
      if (rd_we || misalign || badform) done = 1'b1;
    end
    check(done, "R10", "completion", {31'b0, done}, 32'h1);
    check(badform == exp_bad, "R9", "badform", {31'b0, badform}, {31'b0, exp_bad});
    check(misalign == exp_mis, "R8", "misalign", {31'b0, misalign}, {31'b0, exp_mis});
    check(seen_req == !(exp_bad || exp_mis), "R10", "request issued",
          {31'b0, seen_req}, {31'b0, !(exp_bad || exp_mis)});
    if (exp_bad || exp_mis) begin
      check(!rd_we && !ra_we, "R8", "no write on error", {30'b0, rd_we, ra_we}, 32'h0);
    end else begin
      check(seen_addr == ea, areq, "address", seen_addr, ea);
      check(seen_size == sz, "R10", "request size", {30'b0, seen_size}, {30'b0, sz});
      check(rd_data == exp_data, dreq, "load data", rd_data, exp_data);
      check(rd_idx == rd, dreq, "dest index", {27'b0, rd_idx}, {27'b0, rd});
      check(ra_we == up, "R7", "base write strobe", {31'b0, ra_we}, {31'b0, up});
      if (up) begin
        check(ra_data == ea, "R7", "base write value", ra_data, ea);
        check(ra_idx == ra, "R7", "base write index", {27'b0, ra_idx}, {27'b0, ra});
      end
    end
    @(negedge clk);
    check(!rd_we && !ra_we && !misalign && !badform && op_ready, "R10", "one-cycle strobes",
          {27'b0, rd_we, ra_we, misalign, badform, op_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_ready && !mem_req && !rd_we && !ra_we && !misalign && !badform, "R10",
          "reset state", {26'b0, op_ready, mem_req, rd_we, ra_we, misalign, badform},
          32'h20);

    // full sweep over size, offset, extension, update and address form
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
        for (int sg = 0; sg < 2; sg++)
          for (int up = 0; up < 2; up++)
            for (int ix = 0; ix < 2; ix++)
              run(2'(sz), 1'(sg), 1'(up), 1'(ix), 5'd5, 5'd7,
                  32'h0000_1000 + 32'(off * 12), 32'h0000_0040 + 32'(off),
                  16'hFFE0 + 16'(off), "R1");

    // R2: base register 0 in non-update forms reads as zero
    run(2'b10, 1'b0, 1'b0, 1'b0, 5'd3, 5'd0, 32'hDEAD_0000, 32'h0, 16'h0124, "R2");
    run(2'b00, 1'b0, 1'b0, 1'b1, 5'd3, 5'd0, 32'hDEAD_0000, 32'h0000_0203, 16'h0, "R2");
    // R9: invalid update forms, including precedence over misalignment
    run(2'b01, 1'b1, 1'b1, 1'b0, 5'd4, 5'd0, 32'h100, 32'h0, 16'h0002, "R1");
    run(2'b10, 1'b0, 1'b1, 1'b1, 5'd9, 5'd9, 32'h100, 32'h8, 16'h0, "R1");
    run(2'b10, 1'b0, 1'b1, 1'b0, 5'd9, 5'd9, 32'h101, 32'h0, 16'h0, "R1");
    // R1: wrap-around in both forms
    run(2'b10, 1'b0, 1'b1, 1'b1, 5'd2, 5'd6, 32'hFFFF_FFF0, 32'h0000_0024, 16'h0, "R1");
    run(2'b01, 1'b1, 1'b0, 1'b0, 5'd2, 5'd6, 32'h0000_0010, 32'h0, 16'h8000, "R1");
    // R5/R6: sign bit set and clear across many words
    for (int w = 0; w < 32; w++) begin
      run(2'b01, 1'b1, 1'b0, 1'b1, 5'd1, 5'd8, 32'h0000_2000, 32'(w * 4 + 2), 16'h0, "R1");
      run(2'b00, 1'b1, 1'b0, 1'b1, 5'd1, 5'd8, 32'h0000_2000, 32'(w * 4 + 1), 16'h0, "R1");
    end

    summary();
  end

endmodule